// File: doc/BRIEF.md
# Streaming Bandwidth Limiter

This block sits on the request path of one processing element. It limits how much memory bandwidth a class of tagged streaming requests may use. Software programs a 64-bit control word. The word holds an enable bit, a hard/soft mode bit, a scaling bit and a fixed-point cap on bandwidth. The cap is expressed relative to the bandwidth the element has available. With scaling off it is a pure fraction. With scaling on it has a 16-bit integer part and a 16-bit fraction, so it can go above 1.0.

Time is divided into back-to-back accounting windows of 2^N cycles. In each window the block counts granted beats, meaning cycles in which a request and the downstream ready are both high and the block is not holding the request back. It compares that count with a budget of floor(cap × 2^N). A beat is the unit of one request per cycle.

Once the count reaches the budget, the block stops passing requests for the rest of the window:
- In hard mode it stops them unconditionally.
- In soft mode it stops them only while the downstream-saturation input is high.

Control settings written by software are visible on readback on the next cycle. They steer the limiter from the next window boundary on, so the counters and budget are never mixed within a window.

Top module: `bw_limiter`

## Requirements
- R1: Out of reset the control word reads back as all zeros and the limiter is disabled.
- R2: With the enable bit (bit 62) at 0 in the active settings, mem_valid_o equals req_valid_i and req_ready_o equals mem_ready_i in every cycle.
- R3: With enable at 1 and the mode bit (bit 61) at 1 (hard), the block stalls once the window's granted-beat count reaches the budget, whatever sat_i is. A window therefore never grants more beats than the budget.
- R4: With enable at 1 and mode bit 61 at 0 (soft), the block stalls only in cycles where the count has reached the budget and sat_i is 1. In every other cycle requests pass through.
- R5: With the scaling bit (bit 63) at 1, the cap is bits [31:16].[15:0] (integer.fraction). A cap of 1.0 or more gives a budget of at least 2^N, so a full window is never throttled.
- R6: A write with bit 63 at 0 stores bits [31:16] as zero, and the cap is the bits [15:0] fraction only.
- R7: A write stores bits [60:32] as zero, and stores the low 16−FRAC_W fraction bits as zero.
- R8: The budget per window is floor(cap × 2^N / 2^16) beats. A beat is counted in a cycle with req_valid_i, mem_ready_i and no stall.
- R9: A write appears on cfg_rdata_o on the next cycle, but it steers the limiter only from the next window boundary. A boundary is the clock edge that ends the window's last cycle. A write sampled on that same edge takes effect one window later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_wdata_i | input | 64 | Control-word write data |
| cfg_rdata_o | output | 64 | Stored control word |
| sat_i | input | 1 | Downstream path reports saturation |
| req_valid_i | input | 1 | Request valid from the requester |
| req_ready_o | output | 1 | Ready returned to the requester |
| mem_valid_o | output | 1 | Request valid toward memory |
| mem_ready_i | input | 1 | Ready from memory |

## Verification
Two events can fall in the same cycle: a software write to the control word, and the window boundary at which the active settings are reloaded and the beat counter clears. The bench provokes this by waiting until its own model reaches the last cycle of a window and raising the write strobe there. It then checks that the window after the boundary still obeys the old cap and that only the one after it obeys the new cap. Stall decisions, counter clears and saturation toggles are also compared cycle by cycle against a behavioural model, including phases with a gappy downstream ready.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
  localparam int unsigned SCALE_BIT = 63;
  localparam int unsigned EN_BIT    = 62;
  localparam int unsigned HARD_BIT  = 61;

  typedef struct packed {
    logic        en;
    logic        hard;
    logic [31:0] cap;
  } bwl_ctrl_t;
endpackage

// File: rtl/bwl_cfg_reg.sv
module bwl_cfg_reg #(
  parameter int unsigned FRAC_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] cfg_o
);
  import bwl_pkg::*;

  localparam logic [15:0] FRAC_MASK = 16'hFFFF << (16 - FRAC_W);

  logic [63:0] keep;
  logic [63:0] cfg_q;

  always_comb begin
    keep = {3'b111, 29'b0, {16{wdata_i[SCALE_BIT]}}, FRAC_MASK};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i & keep;
  end

  assign cfg_o = cfg_q;

  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[60:32] == '0);
  a_r6_int_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[SCALE_BIT] |-> cfg_q[31:16] == '0);

  if (FRAC_W < 16) begin : g_lsb_chk
    a_r7_frac_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[15-FRAC_W:0] == '0);
  end
endmodule

// File: rtl/bwl_budget.sv
module bwl_budget #(
  parameter int unsigned WIN_LOG2 = 6,
  localparam int unsigned BW      = 16 + WIN_LOG2
) (
  input  logic [31:0]   cap_i,
  output logic [BW-1:0] budget_o
);
  // budget = floor(cap * 2^N / 2^16)
  if (WIN_LOG2 <= 16) begin : g_shr
    assign budget_o = BW'(cap_i >> (16 - WIN_LOG2));
  end else begin : g_shl
    assign budget_o = {cap_i, {(WIN_LOG2-16){1'b0}}};
  end
endmodule

// File: rtl/bwl_meter.sv
module bwl_meter
  import bwl_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bwl_ctrl_t ctrl_i,
  input  logic      grant_i,
  input  logic      sat_i,
  output logic      block_o
);
  localparam int unsigned BW = 16 + WIN_LOG2;
  localparam int unsigned UW = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] wcnt_q;
  logic [UW-1:0]       used_q;
  bwl_ctrl_t           act_q;
  logic [BW-1:0]       budget;
  logic                wlast;
  logic                at_cap;

  bwl_budget #(.WIN_LOG2(WIN_LOG2)) u_budget (
    .cap_i   (act_q.cap),
    .budget_o(budget)
  );

  assign wlast  = (wcnt_q == '1);
  assign at_cap = (BW'(used_q) >= budget);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      used_q <= '0;
      act_q  <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
      if (wlast) begin
        used_q <= '0;
        act_q  <= ctrl_i;
      end else if (grant_i) begin
        used_q <= used_q + 1'b1;
      end
    end
  end

  assign block_o = act_q.en & at_cap & (act_q.hard | sat_i);

  a_r3_hard_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.en && act_q.hard) |-> BW'(used_q) <= budget);
  a_r9_win_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wlast |=> used_q == '0);
  a_r9_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wlast |=> $stable(act_q));
  a_r8_no_grant_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> !grant_i);
endmodule

// File: rtl/bw_limiter.sv
module bw_limiter
  import bwl_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 6,
  parameter int unsigned FRAC_W   = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [63:0] cfg_wdata_i,
  output logic [63:0] cfg_rdata_o,
  input  logic        sat_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  output logic        mem_valid_o,
  input  logic        mem_ready_i
);
  logic [63:0] cfg_q;
  bwl_ctrl_t   ctrl;
  logic        block;
  logic        grant;

  bwl_cfg_reg #(.FRAC_W(FRAC_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg_q)
  );

  assign ctrl.en   = cfg_q[EN_BIT];
  assign ctrl.hard = cfg_q[HARD_BIT];
  assign ctrl.cap  = cfg_q[31:0];

  bwl_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .grant_i(grant),
    .sat_i  (sat_i),
    .block_o(block)
  );

  assign mem_valid_o = req_valid_i & ~block;
  assign req_ready_o = mem_ready_i & ~block;
  assign grant       = req_valid_i & mem_ready_i & ~block;
  assign cfg_rdata_o = cfg_q;

  a_r9_rdata_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o[63:61] == $past(cfg_wdata_i[63:61]));
endmodule

// File: tb/tb_bw_limiter.sv
`timescale 1ns/1ps
module tb_bw_limiter;
  localparam int unsigned N   = 6;
  localparam int unsigned FW  = 12;
  localparam int          WIN = 1 << N;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wd = '0;
  logic [63:0] cfg_rd;
  logic        sat = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        mem_valid;
  logic        mem_ready = 1'b0;

  bw_limiter #(.WIN_LOG2(N), .FRAC_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .cfg_rdata_o(cfg_rd), .sat_i(sat), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int          m_wpos = 0;
  int          m_used = 0;
  logic [63:0] m_reg  = '0;
  logic [63:0] m_act  = '0;
  bit          m_grant = 0;
  bit          m_we = 0;
  logic [63:0] m_wd = '0;
  int          obs_cnt = 0;
  int          obs_last = 0;
  int          win_idx = 0;

  function automatic logic [63:0] model_mask(logic [63:0] d);
    logic [63:0] r;
    logic [15:0] lo;
    r = '0;
    r[63] = d[63]; r[62] = d[62]; r[61] = d[61];
    lo = d[15:0];
    for (int b = 0; b < 16 - FW; b++) lo[b] = 1'b0;
    r[15:0] = lo;
    if (d[63]) r[31:16] = d[31:16];
    return r;
  endfunction

  function automatic longint model_budget(logic [63:0] a);
    longint c;
    c = longint'(a[31:0]);
    return (c * WIN) / 65536;
  endfunction

  function automatic bit model_block();
    return m_act[62] && (longint'(m_used) >= model_budget(m_act)) && (m_act[61] || sat);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit b;
      b = model_block();
      chk(mem_valid == (req_valid && !b), "R2/R3/R4", "mem_valid", mem_valid, req_valid && !b);
      chk(req_ready == (mem_ready && !b), "R2/R3/R4", "req_ready", req_ready, mem_ready && !b);
      m_grant = req_valid && mem_ready && !b;
      m_we    = cfg_we;
      m_wd    = cfg_wd;
      if (mem_valid && mem_ready) obs_cnt++;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_wpos == WIN - 1) begin
        m_used = 0; m_act = m_reg; m_wpos = 0;
        obs_last = obs_cnt; obs_cnt = 0; win_idx++;
      end else begin
        if (m_grant) m_used++;
        m_wpos++;
      end
      if (m_we) m_reg = model_mask(m_wd);
      m_we = 0; m_grant = 0;
    end
  end

  task automatic wr(logic [63:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = d;
    @(negedge clk); cfg_we = 1'b0;
    #1;
  endtask

  task automatic wait_win(int k);
    int t;
    t = win_idx + k;
    wait (win_idx >= t);
    @(negedge clk); #2;
  endtask

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  localparam logic [63:0] EN   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] HARD = 64'h2000_0000_0000_0000;
  localparam logic [63:0] SCL  = 64'h8000_0000_0000_0000;

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; mem_ready = 1'b1;
    #1;
    chk(cfg_rd == 64'h0, "R1", "reset rdata", cfg_rd, 0);
    chk(mem_valid == 1'b1, "R1", "reset pass", mem_valid, 1);

    // R2 disabled, full stream
    wait_win(2);
    chk(obs_last == WIN, "R2", "disabled beats", obs_last, WIN);

    // R3 hard 0.25 -> 16, sat irrelevant
    wr(EN | HARD | 64'h4000);
    wait_win(2);
    chk(obs_last == 16, "R3", "hard beats", obs_last, 16);
    sat = 1'b1;
    wait_win(1);
    chk(obs_last == 16, "R3", "hard beats sat", obs_last, 16);

    // R4 soft
    wr(EN | 64'h4000);
    wait_win(2);
    chk(obs_last == 16, "R4", "soft sat beats", obs_last, 16);
    sat = 1'b0;
    wait_win(2);
    chk(obs_last == WIN, "R4", "soft unsat beats", obs_last, WIN);
    for (int i = 0; i < 3 * WIN; i++) begin
      @(negedge clk); sat = (i % 3) == 0;
    end
    sat = 1'b0;

    // R7/R8 fraction truncation, hard
    wr(EN | HARD | 64'h0000_0100_0000_4FFF);
    chk(cfg_rd == (EN | HARD | 64'h4FF0), "R7", "masked rdata", cfg_rd, EN | HARD | 64'h4FF0);
    wait_win(2);
    chk(obs_last == 19, "R8", "trunc beats", obs_last, 19);

    // gappy downstream ready, hard 0.25
    wr(EN | HARD | 64'h4000);
    for (int i = 0; i < 3 * WIN; i++) begin
      @(negedge clk); mem_ready = (i % 2) == 0;
    end
    mem_ready = 1'b1;

    // R6 scaling off drops integer part
    wr(EN | HARD | 64'h0001_4000);
    chk(cfg_rd == (EN | HARD | 64'h4000), "R6", "int dropped", cfg_rd, EN | HARD | 64'h4000);
    wait_win(2);
    chk(obs_last == 16, "R6", "frac-only beats", obs_last, 16);

    // R5 scaling on
    wr(SCL | EN | HARD | 64'h0001_8000);
    chk(cfg_rd == (SCL | EN | HARD | 64'h0001_8000), "R5", "scaled rdata", cfg_rd, SCL | EN | HARD | 64'h0001_8000);
    wait_win(2);
    chk(obs_last == WIN, "R5", "cap>1 beats", obs_last, WIN);
    wr(SCL | EN | HARD | 64'h0000_8000);
    wait_win(2);
    chk(obs_last == 32, "R5", "cap 0.5 beats", obs_last, 32);

    // R9 write on boundary edge applies one window later
    wr(EN | HARD | 64'h4000);
    wait_win(2);
    @(negedge clk);
    while (m_wpos != WIN - 1) @(negedge clk);
    begin
      int w0;
      w0 = win_idx;
      cfg_we = 1'b1; cfg_wd = 64'h0;
      @(negedge clk); cfg_we = 1'b0;
      #1;
      chk(cfg_rd == 64'h0, "R9", "rdata next cycle", cfg_rd, 0);
      wait (win_idx >= w0 + 2); @(negedge clk); #2;
      chk(obs_last == 16, "R9", "old cap window", obs_last, 16);
      wait (win_idx >= w0 + 3); @(negedge clk); #2;
      chk(obs_last == WIN, "R9", "new cap window", obs_last, WIN);
    end

    report();
  end
endmodule